// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This peripheral holds two identical up-counting timer channels behind a small word-wide register bus. Each channel owns a control word, a compare word and a live counter word. Once its run bit is set, a channel's counter steps by one on every clock and wraps past the top of its range. When the running count equals the compare word, a sticky pending bit is raised. If the channel's interrupt enable is also set, a level interrupt line goes high and stays high until software clears the pending bit by writing a 1 to it.

The first channel is normally left running as a free time base that software reads at will. The second channel serves one-shot events. Software stops it, sets the interrupt enable, zeroes the counter, loads the compare word and then sets the run bit. The interrupt then fires a fixed number of cycles later. The two register groups start at byte offsets 0x08 and 0x14, so consecutive groups are 12 bytes apart. Every other offset reads as zero and ignores writes.

Top module: `cmt_top`

## Requirements
- R1: After reset, the control, compare and counter words of both channels read as zero, both interrupt lines are low and the ready signal is low.
- R2: Channel 0 occupies byte offsets 0x08 (control), 0x0C (compare) and 0x10 (counter). Channel 1 occupies 0x14, 0x18 and 0x1C. A read at any other offset, including an offset that is not word aligned, returns zero. A write there changes no register.
- R3: In the control word, bit 0 is the pending flag, bit 1 is the interrupt enable and bit 2 is the run bit. Bits 31 to 3 always read as zero.
- R4: While the run bit is set, the counter increases by one per clock. While it is clear, the counter holds its value.
- R5: The pending flag is set on the clock edge at which a running counter equals the compare word. After the sequence stop, counter=0, compare=N, run, the interrupt line rises N+1 cycles after the edge that sets the run bit.
- R6: Writing 1 to control bit 0 clears the pending flag. Writing 0 to that bit leaves the flag unchanged.
- R7: A channel's interrupt line is high exactly when its pending flag and its interrupt enable are both set. The line stays high until the flag is cleared. Setting the enable while the flag is already pending raises the line.
- R8: The counter word can be written at any time. A write takes priority over the increment in the same cycle, so a read issued on the next cycle returns the written value.
- R9: The counter wraps from 0xFFFFFFFF to 0x00000000 and keeps counting.
- R10: If a match and a write of 1 to the pending bit fall on the same clock edge, the flag stays set.
- R11: Every access (bus_sel high at a clock edge) is answered by bus_ready high in the following cycle. Read data is valid in that same cycle. bus_ready is low in any cycle that follows an edge with no access.
- R12: The channels are independent. Activity on one channel changes no register and no interrupt line of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access answered |
| irq | output | 2 | Level interrupt per channel, bit n for channel n |

## Verification
The hardest situation to reach from the ports is a write-1-to-clear that lands on the exact edge where the counter matches. The bench reaches it by writing the counter to the compare value while the channel is running. It then issues the clearing write on the very next bus cycle, which makes the two events coincide on one edge. The one-shot interrupt latency, the counter wrap and the priority of a counter write over the increment are all checked at exact cycle offsets. Each offset is taken from the single-cycle bus timing.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CH_FIRST_BASE = 8;   // byte offset of channel 0 group
    localparam int CH_STRIDE     = 12;  // bytes between groups
    localparam int OFF_CTL       = 0;
    localparam int OFF_CMP       = 4;
    localparam int OFF_VAL       = 8;

    localparam int CTL_PEND_BIT  = 0;
    localparam int CTL_IE_BIT    = 1;
    localparam int CTL_RUN_BIT   = 2;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_CTL  = 2'd1,
        REG_CMP  = 2'd2,
        REG_VAL  = 2'd3
    } reg_kind_e;

    // packed so that pend lands on bit 0, ie on bit 1, run on bit 2
    typedef struct packed {
        logic run;
        logic ie;
        logic pend;
    } ctl_t;

    function automatic int ch_base(input int ch);
        return CH_FIRST_BASE + ch * CH_STRIDE;
    endfunction

endpackage

// File: rtl/cmt_decode.sv
module cmt_decode
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] hit,
    output reg_kind_e         kind
);

    always_comb begin
        hit  = '0;
        kind = REG_NONE;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(ch_base(c) + OFF_CTL)) begin
                hit[c] = 1'b1;
                kind   = REG_CTL;
            end else if (addr == ADDR_W'(ch_base(c) + OFF_CMP)) begin
                hit[c] = 1'b1;
                kind   = REG_CMP;
            end else if (addr == ADDR_W'(ch_base(c) + OFF_VAL)) begin
                hit[c] = 1'b1;
                kind   = REG_VAL;
            end
        end
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_cmp,
    input  logic              wr_val,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] cnt,
    output logic              irq
);

    logic match;

    assign match = ctl.run && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            cmp <= '0;
            cnt <= '0;
        end else begin
            if (wr_ctl) begin
                ctl.run <= wdata[CTL_RUN_BIT];
                ctl.ie  <= wdata[CTL_IE_BIT];
            end
            // a match beats a same-edge clear
            if (match) begin
                ctl.pend <= 1'b1;
            end else if (wr_ctl && wdata[CTL_PEND_BIT]) begin
                ctl.pend <= 1'b0;
            end
            if (wr_cmp) begin
                cmp <= wdata;
            end
            // a software load beats the increment
            if (wr_val) begin
                cnt <= wdata;
            end else if (ctl.run) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign irq = ctl.pend & ctl.ie;

endmodule

// File: rtl/cmt_rdmux.sv
module cmt_rdmux
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] hit,
    input  reg_kind_e         kind,
    input  ctl_t              ctl [NUM_CH],
    input  logic [DATA_W-1:0] cmp [NUM_CH],
    input  logic [DATA_W-1:0] cnt [NUM_CH],
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) begin
                unique case (kind)
                    REG_CTL:  word = DATA_W'(ctl[c]);
                    REG_CMP:  word = cmp[c];
                    REG_VAL:  word = cnt[c];
                    default:  word = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmt_top.sv
module cmt_top
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0] dec_hit;
    reg_kind_e         dec_kind;
    logic [NUM_CH-1:0] wr_ctl;
    logic [NUM_CH-1:0] wr_cmp;
    logic [NUM_CH-1:0] wr_val;
    ctl_t              ctl_q [NUM_CH];
    logic [DATA_W-1:0] cmp_q [NUM_CH];
    logic [DATA_W-1:0] cnt_q [NUM_CH];
    logic [DATA_W-1:0] rd_word;
    logic              do_wr;
    logic              do_rd;

    assign do_wr = bus_sel & bus_we;
    assign do_rd = bus_sel & ~bus_we;

    cmt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .kind (dec_kind)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_ctl[c] = do_wr && dec_hit[c] && (dec_kind == REG_CTL);
        assign wr_cmp[c] = do_wr && dec_hit[c] && (dec_kind == REG_CMP);
        assign wr_val[c] = do_wr && dec_hit[c] && (dec_kind == REG_VAL);

        cmt_channel #(.DATA_W(DATA_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .wr_ctl (wr_ctl[c]),
            .wr_cmp (wr_cmp[c]),
            .wr_val (wr_val[c]),
            .wdata  (bus_wdata),
            .ctl    (ctl_q[c]),
            .cmp    (cmp_q[c]),
            .cnt    (cnt_q[c]),
            .irq    (irq[c])
        );
    end

    cmt_rdmux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rd (
        .hit  (dec_hit),
        .kind (dec_kind),
        .ctl  (ctl_q),
        .cmp  (cmp_q),
        .cnt  (cnt_q),
        .word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_sel;
            bus_rdata <= do_rd ? rd_word : '0;
        end
    end

endmodule

// File: rtl/cmt_top_chk.sv
module cmt_top_chk
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] hit,
    input logic [NUM_CH-1:0] wr_ctl,
    input logic [NUM_CH-1:0] wr_val,
    input ctl_t              ctl [NUM_CH],
    input logic [DATA_W-1:0] cmp [NUM_CH],
    input logic [DATA_W-1:0] cnt [NUM_CH]
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!bus_ready && irq == '0));

    p_ready_after_access_r11: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ready);

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ready);

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && hit == '0) |=> bus_rdata == '0);

    p_irq_onehot_addr_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_reset_regs_r1: assert property (@(posedge clk)
            rst |=> (cnt[c] == '0 && cmp[c] == '0 && ctl[c] == '0));

        p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
            (ctl[c].run && !wr_val[c]) |=> cnt[c] == $past(cnt[c]) + 1'b1);

        p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!ctl[c].run && !wr_val[c]) |=> $stable(cnt[c]));

        p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
            wr_val[c] |=> cnt[c] == $past(bus_wdata));

        p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
            (ctl[c].run && !wr_val[c] && cnt[c] == '1) |=> cnt[c] == '0);

        p_match_sets_r5_r10: assert property (@(posedge clk) disable iff (rst)
            (ctl[c].run && cnt[c] == cmp[c]) |=> ctl[c].pend);

        p_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_ctl[c] && bus_wdata[CTL_PEND_BIT] && !(ctl[c].run && cnt[c] == cmp[c]))
            |=> !ctl[c].pend);

        p_pend_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (ctl[c].pend && !(wr_ctl[c] && bus_wdata[CTL_PEND_BIT])) |=> ctl[c].pend);

        p_irq_held_r7: assert property (@(posedge clk) disable iff (rst)
            (irq[c] && !wr_ctl[c]) |=> irq[c]);
    end

endmodule

bind cmt_top cmt_top_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .irq       (irq),
    .hit       (dec_hit),
    .wr_ctl    (wr_ctl),
    .wr_val    (wr_val),
    .ctl       (ctl_q),
    .cmp       (cmp_q),
    .cnt       (cnt_q)
);

// File: tb/cmt_top_tb.sv
module cmt_top_tb;

    localparam logic [7:0] C0_CTL = 8'h08, C0_CMP = 8'h0C, C0_VAL = 8'h10;
    localparam logic [7:0] C1_CTL = 8'h14, C1_CMP = 8'h18, C1_VAL = 8'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [1:0]  irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [32:0] exp_q [$];   // bit 32 = compare data
    string       tag_q [$];

    always #2.5 clk = ~clk;

    cmt_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        exp_q.push_back({1'b0, 32'h0});
        tag_q.push_back("R11");
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        exp_q.push_back({1'b1, e});
        tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: pops one expected item for each answered access
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0) begin
                logic [32:0] it;
                string       t;
                it = exp_q.pop_front();
                t  = tag_q.pop_front();
                n_cmp++;
                if (bus_ready !== 1'b1) begin
                    n_bad++;
                    $display("FAIL R11: ready actual %b expected 1", bus_ready);
                end else if (it[32] && bus_rdata !== it[31:0]) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, it[31:0]);
                end
            end else if (bus_ready !== 1'b0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R11: idle ready actual %b expected 0", bus_ready);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", {30'h0, irq}, 32'h0);
        check("R1", {31'h0, bus_ready}, 32'h0);
        bus_rd(C0_CTL, 0, "R1"); bus_rd(C0_CMP, 0, "R1"); bus_rd(C0_VAL, 0, "R1");
        bus_rd(C1_CTL, 0, "R1"); bus_rd(C1_CMP, 0, "R1"); bus_rd(C1_VAL, 0, "R1");

        // R3 upper control bits read zero
        bus_wr(C0_CTL, 32'hFFFF_FFFA);
        bus_rd(C0_CTL, 32'h2, "R3");
        check("R3", {30'h0, irq}, 32'h0);
        bus_wr(C0_CTL, 32'h0);

        // R2 unmapped offsets
        bus_wr(8'h00, 32'hFFFF_FFFF); bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_wr(8'h0A, 32'hFFFF_FFFF); bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_rd(8'h00, 0, "R2"); bus_rd(8'h04, 0, "R2");
        bus_rd(8'h20, 0, "R2"); bus_rd(8'h0A, 0, "R2");
        bus_rd(C0_CMP, 0, "R2"); bus_rd(C0_VAL, 0, "R2");
        bus_rd(C1_CTL, 0, "R2"); bus_rd(C1_VAL, 0, "R2");

        // R4 hold while stopped, step while running
        bus_wr(C0_VAL, 32'd100);
        bus_rd(C0_VAL, 32'd100, "R4"); bus_rd(C0_VAL, 32'd100, "R4");
        bus_wr(C0_CTL, 32'h4);
        bus_rd(C0_VAL, 32'd100, "R4"); bus_rd(C0_VAL, 32'd101, "R4");
        bus_rd(C0_VAL, 32'd102, "R4");
        // R8 load beats increment
        bus_wr(C0_VAL, 32'd500);
        bus_rd(C0_VAL, 32'd500, "R8"); bus_rd(C0_VAL, 32'd501, "R8");

        // R9 wrap, then match at zero with interrupt masked (R5, R7)
        bus_wr(C0_CTL, 32'h0);
        bus_wr(C0_VAL, 32'hFFFF_FFFE);
        bus_wr(C0_CTL, 32'h4);
        bus_rd(C0_VAL, 32'hFFFF_FFFE, "R9"); bus_rd(C0_VAL, 32'hFFFF_FFFF, "R9");
        bus_rd(C0_VAL, 32'h0, "R9");
        bus_rd(C0_CTL, 32'h5, "R5");
        check("R7", {30'h0, irq}, 32'h0);
        bus_wr(C0_CTL, 32'h1);
        bus_rd(C0_CTL, 32'h0, "R6");

        // R5 one-shot sequence on channel 1 with N = 20
        bus_wr(C1_CTL, 32'h2);
        bus_wr(C1_VAL, 32'h0);
        bus_wr(C1_CMP, 32'd20);
        bus_wr(C1_CTL, 32'h6);
        cyc = 0;
        while (!irq[1] && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check("R5", cyc, 21);
        check("R12", {31'h0, irq[0]}, 32'h0);
        repeat (10) @(negedge clk);
        check("R7", {31'h0, irq[1]}, 32'h1);
        bus_rd(C1_CTL, 32'h7, "R5");
        bus_wr(C1_CTL, 32'h6);
        bus_rd(C1_CTL, 32'h7, "R6");
        check("R6", {31'h0, irq[1]}, 32'h1);
        bus_wr(C1_CTL, 32'h7);
        check("R7", {31'h0, irq[1]}, 32'h0);
        bus_rd(C1_CTL, 32'h6, "R6");

        // R7 pending while masked, then enable raises the line
        bus_wr(C1_CTL, 32'h0);
        bus_wr(C1_VAL, 32'h0);
        bus_wr(C1_CMP, 32'd3);
        bus_wr(C1_CTL, 32'h4);
        repeat (10) @(negedge clk);
        check("R7", {31'h0, irq[1]}, 32'h0);
        bus_rd(C1_CTL, 32'h5, "R7");
        bus_wr(C1_CTL, 32'h6);
        check("R7", {31'h0, irq[1]}, 32'h1);

        // R10 match and clear on the same edge
        bus_wr(C1_CMP, 32'd50);
        bus_wr(C1_VAL, 32'd50);
        bus_wr(C1_CTL, 32'h7);
        bus_rd(C1_CTL, 32'h7, "R10");
        check("R10", {31'h0, irq[1]}, 32'h1);
        bus_wr(C1_CTL, 32'h7);
        bus_rd(C1_CTL, 32'h6, "R10");
        check("R6", {31'h0, irq[1]}, 32'h0);

        // R12 channel 0 untouched by channel 1 activity
        bus_rd(C0_CTL, 32'h0, "R12");
        bus_rd(C0_CMP, 32'h0, "R12");
        bus_rd(C0_VAL, 32'd3, "R12");
        check("R12", {31'h0, irq[0]}, 32'h0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule